// File: doc/BRIEF.md
# Cursor-Tagged Recirculating Character Memory

This block is the storage for a character display held in a recirculating serial loop. The loop is divided into `N_SLOTS` fixed slots of eight bit-times each: one tag bit, then a 7-bit character code. Every slot passes through a parallel entry stage once per frame. Exactly one slot carries a set tag bit, and that slot is the cursor position. The cursor has no separate position register. It travels with the data.

A keyboard presents a 7-bit code together with a one-cycle strobe. The code is held until the tagged slot next reaches the entry stage. In that slot time three things happen: the tag leaves the slot, every code bit of the slot is replaced by the held code, and the tag is placed on the following slot. Typing over an existing character therefore destroys it. A display or transfer controller follows the loop through a serial bit output with a slot-start marker, the index of the slot being emitted, and a flag that marks the slot in which the cursor was found.

Top module: `cursor_char_loop`

## Requirements
- R1: Each slot leaves on `ser_bit` over 8 consecutive cycles, least significant bit first. Bit 0 is the cursor tag, and output bit k+1 carries code bit k. `ser_first` is high only on bit 0. `slot_idx` holds the slot number for all 8 bits, and that number counts 0 to N_SLOTS-1 and then returns to 0.
- R2: After reset every code is 0, only slot 0 carries the tag, and the first slot emitted is slot 0.
- R3: When no keystroke is pending, every slot's code and tag come back unchanged in each frame.
- R4: An accepted code replaces all 7 code bits of the tagged slot on the tagged slot's next pass through the entry stage.
- R5: In that same slot time the tag moves to the following slot. From slot N_SLOTS-1 it moves to slot 0.
- R6: Exactly one slot in the loop carries the tag at all times.
- R7: A strobe that arrives while a code is already pending has no effect on the code that is written.
- R8: The edited slot is emitted no more than N_SLOTS*8+1 cycles after the strobe. Each pass of the cursor consumes at most one pending code.
- R9: `cursor_here` stays high for all 8 output cycles of the slot that carried the tag when it entered the entry stage, and stays low for the other slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst | input | 1 | Synchronous reset, active high |
| key_strobe | input | 1 | One-cycle keystroke request |
| key_code | input | 7 | Character code, sampled together with the strobe |
| ser_bit | output | 1 | Serial loop output, one bit per cycle |
| ser_first | output | 1 | High on bit 0 (the tag bit) of each slot |
| slot_idx | output | $clog2(N_SLOTS) | Number of the slot currently on `ser_bit` |
| cursor_here | output | 1 | The emitted slot held the cursor when it entered the entry stage |

## Verification
The checker assumes that `key_strobe` and `key_code` change only between clock edges. It also assumes the strobe is a single-cycle pulse, and that strobes arrive far enough apart for the loop to settle, except where a second strobe is sent on purpose to test R7. The bench drives inputs only on falling edges and holds each strobe for one cycle. Between keystrokes it waits at least two full frames, so the tag-spacing property only ever sees gaps of one frame, or of one frame plus one slot right after an edit.

// File: rtl/ccl_pkg.sv
package ccl_pkg;
    localparam int CODE_W = 7;
    localparam int SLOT_W = CODE_W + 1;

    typedef struct packed {
        logic              pend;
        logic [CODE_W-1:0] code;
    } key_t;
endpackage

// File: rtl/ccl_timer.sv
module ccl_timer #(
    parameter int N_SLOTS = 16,
    parameter int PH_W    = 3,
    parameter int IDX_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    output logic [PH_W-1:0]  phase,
    output logic [IDX_W-1:0] slot
);
    import ccl_pkg::*;
    localparam logic [PH_W-1:0]  LAST_PH   = PH_W'(SLOT_W - 1);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(N_SLOTS - 1);

    typedef struct packed {
        logic [PH_W-1:0]  ph;
        logic [IDX_W-1:0] idx;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (tm_q.ph == LAST_PH) begin
            tm_d.ph  = '0;
            tm_d.idx = (tm_q.idx == LAST_SLOT) ? '0 : tm_q.idx + IDX_W'(1);
        end else begin
            tm_d.ph = tm_q.ph + PH_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tm_q <= '0;
        else     tm_q <= tm_d;
    end

    assign phase = tm_q.ph;
    assign slot  = tm_q.idx;
endmodule

// File: rtl/ccl_key_latch.sv
module ccl_key_latch (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      strobe,
    input  logic [ccl_pkg::CODE_W-1:0] code_in,
    input  logic                      done,
    output logic                      pend,
    output logic [ccl_pkg::CODE_W-1:0] code
);
    import ccl_pkg::*;

    key_t k_d, k_q;

    always_comb begin
        k_d = k_q;
        if (done) k_d.pend = 1'b0;
        if (!k_q.pend && strobe) begin
            k_d.pend = 1'b1;
            k_d.code = code_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) k_q <= '0;
        else     k_q <= k_d;
    end

    assign pend = k_q.pend;
    assign code = k_q.code;
endmodule

// File: rtl/ccl_ring.sv
module ccl_ring #(
    parameter int N_SLOTS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic out_bit,
    input  logic force_tag,
    output logic ce_lsb
);
    import ccl_pkg::*;
    localparam int LOOP_W = (N_SLOTS - 1) * SLOT_W;

    typedef struct packed {
        logic [LOOP_W-1:0] ring;
        logic [SLOT_W-1:0] ce;
    } rg_t;

    rg_t rg_d, rg_q;
    logic in_bit;

    always_comb begin
        in_bit     = rg_q.ring[0] | force_tag;
        rg_d.ce    = {in_bit, rg_q.ce[SLOT_W-1:1]};
        rg_d.ring  = {out_bit, rg_q.ring[LOOP_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rg_q.ring <= '0;
            rg_q.ce   <= SLOT_W'(1);
        end else begin
            rg_q <= rg_d;
        end
    end

    assign ce_lsb = rg_q.ce[0];
endmodule

// File: rtl/cursor_char_loop.sv
module cursor_char_loop #(
    parameter int N_SLOTS = 16,
    localparam int IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int PH_W   = $clog2(ccl_pkg::SLOT_W)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       key_strobe,
    input  logic [ccl_pkg::CODE_W-1:0] key_code,
    output logic                       ser_bit,
    output logic                       ser_first,
    output logic [IDX_W-1:0]           slot_idx,
    output logic                       cursor_here
);
    import ccl_pkg::*;
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(SLOT_W - 1);

    typedef struct packed {
        logic             located;
        logic             tag_hold;
        logic             o_bit;
        logic             o_first;
        logic             o_tag;
        logic [IDX_W-1:0] o_idx;
    } top_t;

    top_t st_d, st_q;

    logic [PH_W-1:0]   phase_w;
    logic [IDX_W-1:0]  slot_w;
    logic              pend_w;
    logic [CODE_W-1:0] key_w;
    logic              ce_lsb_w;
    logic              hit;
    logic              done;
    logic              out_bit;
    logic              located_w;
    logic [PH_W-1:0]   wr_idx;

    ccl_timer #(.N_SLOTS(N_SLOTS), .PH_W(PH_W), .IDX_W(IDX_W)) u_timer (
        .clk(clk), .rst(rst), .phase(phase_w), .slot(slot_w)
    );

    ccl_key_latch u_key (
        .clk(clk), .rst(rst), .strobe(key_strobe), .code_in(key_code),
        .done(done), .pend(pend_w), .code(key_w)
    );

    ccl_ring #(.N_SLOTS(N_SLOTS)) u_ring (
        .clk(clk), .rst(rst), .out_bit(out_bit), .force_tag(hit),
        .ce_lsb(ce_lsb_w)
    );

    always_comb begin
        st_d   = st_q;
        hit    = (phase_w == '0) && pend_w && ce_lsb_w;
        done   = st_q.located && (phase_w == LAST_PH);
        wr_idx = phase_w - PH_W'(1);

        if (phase_w == '0) begin
            out_bit       = hit ? 1'b0 : ce_lsb_w;
            st_d.located  = hit;
            st_d.tag_hold = ce_lsb_w;
            st_d.o_tag    = ce_lsb_w;
        end else begin
            out_bit    = st_q.located ? key_w[wr_idx] : ce_lsb_w;
            st_d.o_tag = st_q.tag_hold;
        end

        st_d.o_bit   = out_bit;
        st_d.o_first = (phase_w == '0);
        st_d.o_idx   = slot_w;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign located_w   = st_q.located;
    assign ser_bit     = st_q.o_bit;
    assign ser_first   = st_q.o_first;
    assign slot_idx    = st_q.o_idx;
    assign cursor_here = st_q.o_tag;
endmodule

// File: rtl/ccl_check.sv
module ccl_check #(
    parameter int N_SLOTS = 16,
    parameter int IDX_W   = 4,
    parameter int PH_W    = 3
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       ser_bit,
    input logic                       ser_first,
    input logic [IDX_W-1:0]           slot_idx,
    input logic                       cursor_here,
    input logic                       key_strobe,
    input logic                       pend,
    input logic [ccl_pkg::CODE_W-1:0] code,
    input logic                       located,
    input logic [PH_W-1:0]            phase
);
    localparam int GAP_W = $clog2(N_SLOTS + 2) + 1;
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(ccl_pkg::SLOT_W - 1);

    logic [PH_W-1:0]  len_q;
    logic             seen_q;
    logic [GAP_W-1:0] gap_q;
    logic             tseen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q   <= '0;
            seen_q  <= 1'b0;
            gap_q   <= '0;
            tseen_q <= 1'b0;
        end else begin
            if (ser_first) begin
                len_q  <= '0;
                seen_q <= 1'b1;
                if (ser_bit) begin
                    gap_q   <= GAP_W'(1);
                    tseen_q <= 1'b1;
                end else begin
                    gap_q <= gap_q + GAP_W'(1);
                end
            end else begin
                len_q <= len_q + PH_W'(1);
            end
        end
    end

    // R1: slot starts are exactly eight output cycles apart
    p_slot_len_r1: assert property (@(posedge clk) disable iff (rst)
        (seen_q && ser_first) |-> (len_q == LAST_PH));

    // R6: tag reappears after one frame, or one frame plus one slot after an edit
    p_one_tag_r6: assert property (@(posedge clk) disable iff (rst)
        (tseen_q && ser_first) |->
            (ser_bit ? (gap_q == GAP_W'(N_SLOTS) || gap_q == GAP_W'(N_SLOTS + 1))
                     : (gap_q <= GAP_W'(N_SLOTS))));

    // R7: held code is untouched by a strobe while pending
    p_hold_code_r7: assert property (@(posedge clk) disable iff (rst)
        (pend && key_strobe) |=> $stable(code));

    // R8: finishing a write empties the pending latch
    p_one_write_r8: assert property (@(posedge clk) disable iff (rst)
        (located && phase == LAST_PH) |=> !pend);

    // R9: cursor flag only changes at a slot start
    p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !ser_first |-> $stable(cursor_here));
endmodule

bind cursor_char_loop ccl_check #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W), .PH_W(PH_W)) u_chk (
    .clk(clk), .rst(rst), .ser_bit(ser_bit), .ser_first(ser_first),
    .slot_idx(slot_idx), .cursor_here(cursor_here), .key_strobe(key_strobe),
    .pend(pend_w), .code(key_w), .located(located_w), .phase(phase_w)
);

// File: tb/tb_cursor_char_loop.sv
`timescale 1ns/1ps
module tb_cursor_char_loop;
    localparam int N     = 16;
    localparam int FRAME = N * 8;
    localparam int NV    = 18;
    localparam logic [6:0] VEC_CODE [NV] = '{
        7'h41, 7'h7F, 7'h00, 7'h2A, 7'h55, 7'h01, 7'h40, 7'h33, 7'h5A,
        7'h0F, 7'h70, 7'h11, 7'h6C, 7'h3E, 7'h24, 7'h48, 7'h15, 7'h6B };
    localparam int VEC_SLOT [NV] = '{
        0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 14, 15, 0, 1 };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_strobe = 1'b0;
    logic [6:0] key_code = '0;
    logic       ser_bit, ser_first, cursor_here;
    logic [3:0] slot_idx;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;

    logic [6:0] mem [N];
    int         cur;
    logic [6:0] got_code [N];
    logic       got_tag  [N];
    logic       got_flag [N];
    logic       frame_ok;

    cursor_char_loop #(.N_SLOTS(N)) dut (
        .clk(clk), .rst(rst), .key_strobe(key_strobe), .key_code(key_code),
        .ser_bit(ser_bit), .ser_first(ser_first), .slot_idx(slot_idx),
        .cursor_here(cursor_here)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic press(input logic [6:0] c);
        @(negedge clk);
        key_strobe = 1'b1;
        key_code   = c;
        @(negedge clk);
        key_strobe = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic capture();
        frame_ok = 1'b1;
        @(negedge clk);
        while (!(ser_first && slot_idx == 4'd0)) @(negedge clk);
        for (int s = 0; s < N; s++) begin
            got_code[s] = '0;
            for (int b = 0; b < 8; b++) begin
                if (b > 0 || s > 0) @(negedge clk);
                if (ser_first != (b == 0) || slot_idx != 4'(s)) frame_ok = 1'b0;
                if (b == 0) begin
                    got_tag[s]  = ser_bit;
                    got_flag[s] = cursor_here;
                end else begin
                    got_code[s][b-1] = ser_bit;
                end
                if (cursor_here != got_flag[s]) frame_ok = 1'b0;
            end
        end
    endtask

    task automatic compare(input string tag);
        int bad_code = -1;
        int bad_tag  = -1;
        int bad_flag = -1;
        capture();
        chk(frame_ok, {tag, " R1 framing"}, int'(frame_ok), 1);
        for (int s = N - 1; s >= 0; s--) begin
            if (got_code[s] != mem[s]) bad_code = s;
            if (got_tag[s] != (s == cur)) bad_tag = s;
            if (got_flag[s] != (s == cur)) bad_flag = s;
        end
        chk(bad_code < 0, {tag, " R4 codes (slot)"}, bad_code < 0 ? 0 : int'(got_code[bad_code]),
            bad_code < 0 ? 0 : int'(mem[bad_code]));
        chk(bad_tag < 0, {tag, " R6 tag position"}, bad_tag, -1);
        chk(bad_flag < 0, {tag, " R9 cursor flag"}, bad_flag, -1);
    endtask

    initial begin
        for (int s = 0; s < N; s++) mem[s] = '0;
        cur = 0;
        idle(4);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ser_first && slot_idx == 4'd0 && ser_bit, "R2 first slot after reset",
            int'(slot_idx), 0);
        compare("R2 reset frame");
        idle(3 * FRAME);
        compare("R3 idle recirculation");

        for (int i = 0; i < NV; i++) begin
            press(VEC_CODE[i]);
            idle(2 * FRAME);
            mem[VEC_SLOT[i]] = VEC_CODE[i];
            cur = (VEC_SLOT[i] + 1) % N;
            compare($sformatf("R5 vector %0d", i));
        end

        // R7: second strobe while pending
        @(negedge clk);
        key_strobe = 1'b1; key_code = 7'h19;
        @(negedge clk);
        key_code = 7'h66;
        @(negedge clk);
        key_strobe = 1'b0;
        idle(2 * FRAME);
        mem[cur] = 7'h19;
        cur = (cur + 1) % N;
        compare("R7 ignored strobe");

        // R8: latency and edited slot contents
        begin
            int n = 0;
            logic [7:0] sl;
            int         eidx;
            press(7'h5C);
            n = 1;
            @(negedge clk); n++;
            while (!(ser_first && cursor_here) && n < 3 * FRAME) begin
                @(negedge clk); n++;
            end
            chk(n <= FRAME + 1, "R8 write latency", n, FRAME + 1);
            eidx = int'(slot_idx);
            chk(eidx == cur, "R8 edited slot index", eidx, cur);
            sl[0] = ser_bit;
            for (int b = 1; b < 8; b++) begin
                @(negedge clk);
                sl[b] = ser_bit;
            end
            chk(sl == {7'h5C, 1'b0}, "R4 edited slot bits", int'(sl), int'({7'h5C, 1'b0}));
            @(negedge clk);
            chk(ser_first && ser_bit, "R5 tag on following slot", int'(ser_bit), 1);
            mem[cur] = 7'h5C;
            cur = (cur + 1) % N;
        end
        idle(2 * FRAME);
        compare("R6 final frame");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule